// File: doc/BRIEF.md
# Cache Test Port

This block gives software a back door into a four-way, 64-set data cache with 128-bit lines. Software works through three 32-bit registers, selected by a two-bit address: a data register, a tag/status register and a control register. A line is never touched directly. Data goes in through a 128-bit fill buffer and comes out through a 128-bit flush buffer. Each buffer is loaded or read one 32-bit word at a time.

Writing the control register either picks a buffer word, or starts a line operation. The line operations are: write the fill buffer and the tag register into a line, read a line into the flush buffer and the tag register, or invalidate every line. A line operation runs on the clock edge that follows the control write. The interface never stalls, so register accesses may follow each other on consecutive cycles. The storage array is a plain behavioural register array. Normal lookups and refills are not part of this block.

Top module: `cacheTestPort`

## Requirements
- R1: `wrAddr` selects the register written when `wrEn` is high: 0 is data, 1 is tag/status, 2 is control, and 3 writes nothing. A tag/status write is returned unchanged on `tagRdOut` from the next cycle, unless a line read lands on the same edge.
- R2: After reset, `tagRdOut` and `dataRdOut` are zero, both staging buffers are zero and every line is invalid.
- R3: The control register layout is: code in bits 1:0, word select in bits 3:2, way in bits 5:4, set in bits 11:6. With code 00, a data write stores `wrData` into the fill buffer word chosen by the word select. Word select 0 maps to bits 31:0, 1 to bits 63:32, 2 to bits 95:64 and 3 to bits 127:96.
- R4: A data write while the control code is not 00 leaves the fill buffer unchanged.
- R5: `dataRdOut` always shows the flush buffer word chosen by control bits 3:2, using the same word mapping as R3.
- R6: Code 01 writes a line: all 128 fill buffer bits go into the addressed line. Tag/status bits 31:11 become the line tag, bit 10 its valid bit and bit 9 its dirty bit.
- R7: Code 10 reads a line: the addressed line is copied into the flush buffer. The tag/status register becomes {tag, valid, dirty, LRU, 6'b0}, with tag in bits 31:11, valid in bit 10, dirty in bit 9 and LRU in bits 8:6. The LRU field supplied on a write is ignored and reads back as zero.
- R8: Code 11 clears the valid bit of every line and leaves tags, dirty bits and line data unchanged.
- R9: A line operation executes on the clock edge right after its control write. It still executes if another control write follows on the next cycle. A control write with code 00 starts no line operation.
- R10: When a tag/status write lands on the same edge as a line read, the read result wins. A line write on the same edge as a tag/status write uses the tag/status value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (0 data, 1 tag/status, 2 control, 3 none) |
| wrData | input | 32 | Write value |
| dataRdOut | output | 32 | Selected flush buffer word (data register read) |
| tagRdOut | output | 32 | Tag/status register read |

## Verification
Directed sequences fill a line with four distinct words, write it with a tag that carries stray LRU bits, and read it back word by word. This separates the word mapping from the line copy and shows that the LRU bits are dropped. A data write under a non-zero code, a global flush followed by a read, and collisions on consecutive cycles each pin down one ordering rule. Constrained random lines across all sets and ways, with occasional flushes, then check line independence and index decoding against a bench model built from the requirements.

// File: rtl/cacheTestPkg.sv
package cacheTestPkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int WAY_W      = 2;
  localparam int SET_W      = 6;
  localparam int IDX_W      = WAY_W + SET_W;
  localparam int LINES      = 1 << IDX_W;
  localparam int TAG_W      = 21;
  localparam int LRU_W      = 3;

  // control register field positions
  localparam int WSEL_LSB = 2;
  localparam int WAY_LSB  = WSEL_LSB + WSEL_W;
  localparam int SET_LSB  = WAY_LSB + WAY_W;
  localparam int CTRL_W   = SET_LSB + SET_W;

  // tag/status register field positions
  localparam int TAG_LSB   = WORD_W - TAG_W;
  localparam int VALID_BIT = TAG_LSB - 1;
  localparam int DIRTY_BIT = TAG_LSB - 2;
  localparam int LRU_LSB   = DIRTY_BIT - LRU_W;

  typedef enum logic [1:0] {
    OP_BUF   = 2'b00,
    OP_LWR   = 2'b01,
    OP_LRD   = 2'b10,
    OP_FLUSH = 2'b11
  } opCode_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_TAG  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              fillWe;
    logic [WSEL_W-1:0] wordSel;
    logic              lineWrite;
    logic              lineRead;
    logic              flushAll;
    logic [SET_W-1:0]  set;
    logic [WAY_W-1:0]  way;
  } strobe_t;
endpackage

// File: rtl/cacheTestCtrl.sv
module cacheTestCtrl
  import cacheTestPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CTRL_W-1:0] ctrlIn,
  output strobe_t           stb
);
  logic [CTRL_W-1:0] ctrlReg;
  logic              pending;
  logic              ctrlWe;
  opCode_e           code;

  assign ctrlWe = wrEn && (wrAddr == SEL_CTRL);
  assign code   = opCode_e'(ctrlReg[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pending <= 1'b0;
    end else begin
      pending <= ctrlWe && (ctrlIn[1:0] != OP_BUF);
      if (ctrlWe) ctrlReg <= ctrlIn;
    end
  end

  always_comb begin
    stb.fillWe    = wrEn && (wrAddr == SEL_DATA) && (code == OP_BUF);
    stb.wordSel   = ctrlReg[WSEL_LSB +: WSEL_W];
    stb.lineWrite = pending && (code == OP_LWR);
    stb.lineRead  = pending && (code == OP_LRD);
    stb.flushAll  = pending && (code == OP_FLUSH);
    stb.set       = ctrlReg[SET_LSB +: SET_W];
    stb.way       = ctrlReg[WAY_LSB +: WAY_W];
  end
endmodule

// File: rtl/cacheTestData.sv
module cacheTestData
  import cacheTestPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              tagWe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] dataRdOut,
  output logic [WORD_W-1:0] tagRdOut
);
  logic [LINE_W-1:0] fillBuf;
  logic [LINE_W-1:0] flushBuf;
  logic [WORD_W-1:0] tagReg;
  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;
  logic [IDX_W-1:0]  lineIdx;
  logic [WORD_W-1:0] readStatus;

  assign lineIdx = {stb.set, stb.way};
  assign readStatus = {tagArr[lineIdx], validArr[lineIdx], dirtyArr[lineIdx],
                       {LRU_W{1'b0}}, {LRU_LSB{1'b0}}};

  // staging buffers and tag/status register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillBuf  <= '0;
      flushBuf <= '0;
      tagReg   <= '0;
    end else begin
      if (stb.fillWe) fillBuf[stb.wordSel*WORD_W +: WORD_W] <= wrData;
      if (stb.lineRead) begin
        flushBuf <= dataArr[lineIdx];
        tagReg   <= readStatus;
      end else if (tagWe) begin
        tagReg <= wrData;
      end
    end
  end

  // line data: no reset, written only by a line write
  always_ff @(posedge clk) begin
    if (stb.lineWrite) dataArr[lineIdx] <= fillBuf;
  end

  // line status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else if (stb.flushAll) begin
      validArr <= '0;
    end else if (stb.lineWrite) begin
      tagArr[lineIdx]   <= tagReg[TAG_LSB +: TAG_W];
      validArr[lineIdx] <= tagReg[VALID_BIT];
      dirtyArr[lineIdx] <= tagReg[DIRTY_BIT];
    end
  end

  assign dataRdOut = flushBuf[stb.wordSel*WORD_W +: WORD_W];
  assign tagRdOut  = tagReg;
endmodule

// File: rtl/cacheTestPort.sv
module cacheTestPort
  import cacheTestPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic [31:0] dataRdOut,
  output logic [31:0] tagRdOut
);
  strobe_t stb;
  logic    tagWe;

  assign tagWe = wrEn && (wrAddr == SEL_TAG);

  cacheTestCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .ctrlIn (wrData[CTRL_W-1:0]),
    .stb    (stb)
  );

  cacheTestData uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tagWe     (tagWe),
    .wrData    (wrData),
    .dataRdOut (dataRdOut),
    .tagRdOut  (tagRdOut)
  );
endmodule

// File: rtl/cacheTestChecker.sv
module cacheTestChecker
  import cacheTestPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [31:0] wrData,
  input logic [31:0] dataRdOut,
  input logic [31:0] tagRdOut,
  input strobe_t     stb
);
  // R2: registers read zero when reset is released
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (tagRdOut == '0 && dataRdOut == '0));

  // R9: at most one line operation per cycle
  p_single_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.lineWrite, stb.lineRead, stb.flushAll}));

  // R9: a line read executes only right after a control write with code 10
  p_read_follows_ctrl_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.lineRead |-> $past(wrEn && wrAddr == 2'd2 && wrData[1:0] == 2'b10));

  // R6: a line write executes only right after a control write with code 01
  p_write_follows_ctrl_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.lineWrite |-> $past(wrEn && wrAddr == 2'd2 && wrData[1:0] == 2'b01));

  // R9: control code 00 starts no line operation
  p_buf_code_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2 && wrData[1:0] == 2'b00)
      |=> !(stb.lineWrite || stb.lineRead || stb.flushAll));

  // R1: tag/status only changes on a tag write or a line read
  p_tag_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && wrAddr == 2'd1) && !stb.lineRead) |=> $stable(tagRdOut));
endmodule

bind cacheTestPort cacheTestChecker chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .dataRdOut (dataRdOut),
  .tagRdOut  (tagRdOut),
  .stb       (stb)
);

// File: tb/tb_cacheTestPort.sv
`timescale 1ns/1ps
module tb_cacheTestPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd3;
  logic [31:0] wrData = '0;
  logic [31:0] dataRdOut;
  logic [31:0] tagRdOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cacheTestPort dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .dataRdOut(dataRdOut), .tagRdOut(tagRdOut)
  );

  // bench model, built from the requirements
  logic [127:0] mData [256];
  logic [20:0]  mTagA [256];
  bit           mVal  [256];
  bit           mDirty[256];
  logic [127:0] mFill = '0;
  logic [127:0] mFlush = '0;
  logic [31:0]  mTag = '0;
  logic [11:0]  mCtrl = '0;
  bit           mPend = 1'b0;
  int           wlist [64];
  int           wcount = 0;

  function automatic logic [31:0] ctrlVal(int set, int way, int wsel, int code);
    return 32'((set << 6) | (way << 4) | (wsel << 2) | code);
  endfunction

  function automatic void modelEdge(bit en, logic [1:0] addr, logic [31:0] d);
    logic [31:0]  oldTag = mTag;
    logic [127:0] oldFill = mFill;
    logic [1:0]   code = mCtrl[1:0];
    int           idx = int'({mCtrl[11:6], mCtrl[5:4]});
    if (mPend && code == 2'b01) begin
      mData[idx] = oldFill; mTagA[idx] = oldTag[31:11];
      mVal[idx] = oldTag[10]; mDirty[idx] = oldTag[9];
    end
    if (mPend && code == 2'b10) mFlush = mData[idx];
    if (mPend && code == 2'b11) for (int i = 0; i < 256; i++) mVal[i] = 1'b0;
    if (en && addr == 2'd0 && code == 2'b00) mFill[mCtrl[3:2]*32 +: 32] = d;
    if (en && addr == 2'd1) mTag = d;
    if (en && addr == 2'd2) mCtrl = d[11:0];
    if (mPend && code == 2'b10) mTag = {mTagA[idx], mVal[idx], mDirty[idx], 9'b0};
    mPend = en && addr == 2'd2 && d[1:0] != 2'b00;
  endfunction

  task automatic step(bit en, logic [1:0] addr, logic [31:0] d);
    wrEn = en; wrAddr = addr; wrData = d;
    @(posedge clk);
    modelEdge(en, addr, d);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 2'd3;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeLine(int set, int way, logic [127:0] data, logic [31:0] tag);
    for (int w = 0; w < 4; w++) begin
      step(1, 2'd2, ctrlVal(0, 0, w, 0));
      step(1, 2'd0, data[w*32 +: 32]);
    end
    step(1, 2'd1, tag);
    step(1, 2'd2, ctrlVal(set, way, 0, 1));
    step(0, 2'd3, '0);
    if (wcount < 64) begin wlist[wcount] = set * 4 + way; wcount++; end
  endtask

  task automatic readLine(int set, int way, string req);
    step(1, 2'd2, ctrlVal(set, way, 0, 2));
    step(0, 2'd3, '0);
    check({req, " tag/status"}, tagRdOut, mTag);
    for (int w = 0; w < 4; w++) begin
      step(1, 2'd2, ctrlVal(0, 0, w, 0));
      check({req, " word"}, dataRdOut, mFlush[w*32 +: 32]);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] line;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin mVal[i] = 0; mDirty[i] = 0; mTagA[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    check("R2 tag after reset", tagRdOut, 32'h0);
    check("R2 data after reset", dataRdOut, 32'h0);

    // R1 tag/status write and readback; address 3 writes nothing
    step(1, 2'd1, 32'hDEAD_BEEF);
    check("R1 tag readback", tagRdOut, 32'hDEAD_BEEF);
    step(1, 2'd3, 32'h1234_5678);
    check("R1 address 3 ignored", tagRdOut, 32'hDEAD_BEEF);

    // R3 R6 R7: fill, write with stray LRU bits, read back
    writeLine(5, 2, 128'h44444444_33333333_22222222_11111111, 32'hABCD_E7C0 | 32'h600);
    readLine(5, 2, "R3 R6 R7 directed");
    check("R7 LRU reads zero", tagRdOut & 32'h1C0, 32'h0);

    // R4: data write under code 10 is ignored; next line write reuses old fill
    step(1, 2'd2, ctrlVal(5, 2, 1, 2));
    step(1, 2'd0, 32'hFFFF_FFFF);
    step(1, 2'd1, 32'h0000_0C00);
    step(1, 2'd2, ctrlVal(9, 1, 0, 1));
    step(0, 2'd3, '0);
    readLine(9, 1, "R4 ignored data write");

    // R5: word select picks the flush word directly
    step(1, 2'd2, ctrlVal(0, 0, 2, 0));
    check("R5 word select 2", dataRdOut, 32'h3333_3333);

    // R8: flush clears valid, keeps tag, dirty and data
    step(1, 2'd2, ctrlVal(0, 0, 0, 3));
    step(0, 2'd3, '0);
    readLine(5, 2, "R8 after flush");
    check("R8 valid cleared", tagRdOut & 32'h400, 32'h0);

    // R9: line write followed at once by another control write
    line = 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0;
    writeLine(20, 3, line, 32'h1234_5400);
    step(1, 2'd1, 32'h7777_7E00);
    step(1, 2'd2, ctrlVal(21, 0, 0, 1));
    step(1, 2'd2, ctrlVal(0, 0, 0, 0));
    readLine(21, 0, "R9 back-to-back");

    // R10: tag write on the read edge loses; tag write on the write edge is not used
    step(1, 2'd2, ctrlVal(20, 3, 0, 2));
    step(1, 2'd1, 32'hFFFF_FFFF);
    check("R10 read wins over tag write", tagRdOut, mTag);
    step(1, 2'd1, 32'h2222_2600);
    step(1, 2'd2, ctrlVal(30, 1, 0, 1));
    step(1, 2'd1, 32'h5555_5000);
    step(0, 2'd3, '0);
    readLine(30, 1, "R10 write uses prior tag");

    // random lines across sets and ways, with occasional flushes
    for (int it = 0; it < 120; it++) begin
      int act = int'($urandom % 16);
      if (act < 7 || wcount == 0) begin
        line = {$urandom, $urandom, $urandom, $urandom};
        writeLine(int'($urandom % 64), int'($urandom % 4), line, $urandom);
      end else if (act < 15) begin
        int e = wlist[$urandom % wcount];
        readLine(e / 4, e % 4, "R6 R7 random");
      end else begin
        step(1, 2'd2, ctrlVal(int'($urandom % 64), 0, 0, 3));
        step(0, 2'd3, '0);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule